// File: doc/BRIEF.md
# Sticky Error Code Collector

This block gathers one-cycle error pulses from a bank of FIFO checkers and from a set of state-machine, cipher-core and hardened-counter checkers. It folds them into a 32-bit error-code word whose bits never fall until reset. Each FIFO owns one source bit. The kind of FIFO fault goes to three shared type bits: write while full, read while empty, and full and empty at once.

The word drives a fatal-alert level and an interrupt level. A 5-bit test index port lets software force a one-cycle error pulse at any chosen bit position, so that the path from each bit to the alert and the interrupt can be exercised. The test port is honoured only while the shared lock input reports that writes are open.

Top module: `errc_collector`

## Requirements
- R1: A pulse on bit i of any of the three FIFO error inputs sets errCode[i] (i in 0..15) at the next rising clock edge.
- R2: A pulse on fifoWrFullErr sets errCode[28], a pulse on fifoRdEmptyErr sets errCode[29], and a pulse on fifoStateErr sets errCode[30], each at the same edge as the matching source bit.
- R3: A pulse on coreErr[k] (k in 0..6) sets errCode[20+k] at the next rising edge.
- R4: After reset every bit of errCode is zero. Once set, a bit stays set until the next reset.
- R5: fatalAlert is high exactly when any of errCode[15:0] or errCode[26:20] is set. irq is high exactly when any bit of errCode is set.
- R6: A test write (testWrEn high while lockOpen is high) with index n sets errCode[n] at the second rising edge after the write is sampled.
- R7: A test write made while lockOpen is low has no effect on errCode.
- R8: A forced index of 0..15 sets only that source bit and no type bit. A forced index of 28, 29 or 30 sets only that type bit.
- R9: A forced index of 16..19, 27 or 31 has no effect on errCode.
- R10: Sources that pulse in the same cycle, including a forced pulse landing together with hardware pulses, are all recorded at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoWrFullErr | input | 16 | Per-FIFO pulse: write while full |
| fifoRdEmptyErr | input | 16 | Per-FIFO pulse: read while empty |
| fifoStateErr | input | 16 | Per-FIFO pulse: full and empty together |
| coreErr | input | 7 | Pulses from six state/cipher checkers and the counter checker (bits 20..26) |
| lockOpen | input | 1 | High while register writes are permitted |
| testWrEn | input | 1 | Write strobe for the test index |
| testWrIdx | input | 5 | Bit index to force |
| errCode | output | 32 | Sticky error-code word |
| fatalAlert | output | 1 | Fatal alert level |
| irq | output | 1 | Interrupt request level |

## Verification
The forced pulse from the test port and the hardware pulses share one OR into the sticky word, so both can land at the same edge. The bench writes a test index one cycle ahead of a hardware pulse, which makes the delayed forced strobe coincide with it. In some cases both aim at the same bit; in others they aim at different bits and different type flags. The behavioural reference model holds the pending forced index in a queue and predicts the word on every clock, and each divergence is reported against the requirement under test.

// File: rtl/errc_pkg.sv
package errc_pkg;
  parameter int RegW     = 32;
  parameter int NumFifo  = 16;
  parameter int NumCore  = 7;
  parameter int CoreBase = 20;
  parameter int TypeBase = 28;
  parameter int NumType  = 3;
  parameter int IdxW     = $clog2(RegW);

  // Strobes from control to datapath: one forced pulse, already decoded.
  typedef struct packed {
    logic [NumFifo-1:0] src;
    logic [NumType-1:0] kind;
    logic [NumCore-1:0] core;
  } forceStrobe_t;
endpackage

// File: rtl/errc_ctrl.sv
module errc_ctrl
  import errc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            lockOpen,
  input  logic            testWrEn,
  input  logic [IdxW-1:0] testWrIdx,
  output forceStrobe_t    strobe
);
  logic            pendQ;
  logic [IdxW-1:0] idxQ;
  logic            wrAccept;

  assign wrAccept = testWrEn && lockOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      pendQ <= wrAccept;
      if (wrAccept) idxQ <= testWrIdx;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NumFifo; gi++) begin : g_src
      assign strobe.src[gi] = pendQ && (idxQ == IdxW'(gi));
    end
    for (gi = 0; gi < NumType; gi++) begin : g_kind
      assign strobe.kind[gi] = pendQ && (idxQ == IdxW'(TypeBase + gi));
    end
    for (gi = 0; gi < NumCore; gi++) begin : g_core
      assign strobe.core[gi] = pendQ && (idxQ == IdxW'(CoreBase + gi));
    end
  endgenerate

  function automatic logic isReserved(input logic [IdxW-1:0] n);
    return !((int'(n) < NumFifo) ||
             (int'(n) >= CoreBase && int'(n) < CoreBase + NumCore) ||
             (int'(n) >= TypeBase && int'(n) < TypeBase + NumType));
  endfunction

  AST_LOCKED_NO_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (testWrEn && !lockOpen) |=> (strobe == '0)); // R7
  AST_RESERVED_NO_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && isReserved(testWrIdx)) |=> (strobe == '0)); // R9
  AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe) <= 1); // R6
endmodule

// File: rtl/errc_datapath.sv
module errc_datapath
  import errc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumFifo-1:0] fifoWrFullErr,
  input  logic [NumFifo-1:0] fifoRdEmptyErr,
  input  logic [NumFifo-1:0] fifoStateErr,
  input  logic [NumCore-1:0] coreErr,
  input  forceStrobe_t       strobe,
  output logic [RegW-1:0]    errCode,
  output logic               fatalAlert,
  output logic               irq
);
  logic [RegW-1:0]    errQ;
  logic [RegW-1:0]    setVec;
  logic [NumType-1:0] hwKind;

  assign hwKind = {|fifoStateErr, |fifoRdEmptyErr, |fifoWrFullErr};

  always_comb begin
    setVec = '0;
    setVec[NumFifo-1:0]              = fifoWrFullErr | fifoRdEmptyErr | fifoStateErr | strobe.src;
    setVec[CoreBase +: NumCore]      = coreErr | strobe.core;
    setVec[TypeBase +: NumType]      = hwKind | strobe.kind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= '0;
    else       errQ <= errQ | setVec;
  end

  assign errCode    = errQ;
  assign fatalAlert = (|errQ[NumFifo-1:0]) || (|errQ[CoreBase +: NumCore]);
  assign irq        = |errQ;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(errCode)) & ~errCode) == '0)); // R4
  AST_FIFO_SRC: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(fifoWrFullErr | fifoRdEmptyErr | fifoStateErr)) & ~errCode[NumFifo-1:0]) == '0)); // R1
  AST_TYPE_WR: assert property (@(posedge clk) disable iff (!rstN)
    (|fifoWrFullErr) |=> errCode[TypeBase]); // R2
  AST_CORE_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(coreErr)) & ~errCode[CoreBase +: NumCore]) == '0)); // R3
  AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fatalAlert |=> fatalAlert); // R5
endmodule

// File: rtl/errc_collector.sv
module errc_collector
  import errc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumFifo-1:0] fifoWrFullErr,
  input  logic [NumFifo-1:0] fifoRdEmptyErr,
  input  logic [NumFifo-1:0] fifoStateErr,
  input  logic [NumCore-1:0] coreErr,
  input  logic               lockOpen,
  input  logic               testWrEn,
  input  logic [IdxW-1:0]    testWrIdx,
  output logic [RegW-1:0]    errCode,
  output logic               fatalAlert,
  output logic               irq
);
  forceStrobe_t strobe;

  errc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lockOpen  (lockOpen),
    .testWrEn  (testWrEn),
    .testWrIdx (testWrIdx),
    .strobe    (strobe)
  );

  errc_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .fifoWrFullErr  (fifoWrFullErr),
    .fifoRdEmptyErr (fifoRdEmptyErr),
    .fifoStateErr   (fifoStateErr),
    .coreErr        (coreErr),
    .strobe         (strobe),
    .errCode        (errCode),
    .fatalAlert     (fatalAlert),
    .irq            (irq)
  );
endmodule

// File: tb/errc_collector_tb.sv
module errc_collector_tb;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] fifoWrFullErr = '0, fifoRdEmptyErr = '0, fifoStateErr = '0;
  logic [6:0]  coreErr = '0;
  logic        lockOpen = 1'b1, testWrEn = 1'b0;
  logic [4:0]  testWrIdx = '0;
  logic [31:0] errCode;
  logic        fatalAlert, irq;

  int errors = 0, checks = 0, cycles = 0;
  string curReq = "R4";
  logic [31:0] expErr = '0;
  int pendQ[$];

  errc_collector u_dut (
    .clk(clk), .rstN(rstN), .fifoWrFullErr(fifoWrFullErr),
    .fifoRdEmptyErr(fifoRdEmptyErr), .fifoStateErr(fifoStateErr),
    .coreErr(coreErr), .lockOpen(lockOpen), .testWrEn(testWrEn),
    .testWrIdx(testWrIdx), .errCode(errCode), .fatalAlert(fatalAlert), .irq(irq)
  );

  always #(ClkPeriod/2) clk = ~clk;

  // Behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      expErr = '0;
      pendQ.delete();
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (fifoWrFullErr[i] || fifoRdEmptyErr[i] || fifoStateErr[i]) expErr[i] = 1'b1;
      end
      if (fifoWrFullErr != 0)  expErr[28] = 1'b1;
      if (fifoRdEmptyErr != 0) expErr[29] = 1'b1;
      if (fifoStateErr != 0)   expErr[30] = 1'b1;
      for (int k = 0; k < 7; k++) if (coreErr[k]) expErr[20+k] = 1'b1;
      if (pendQ.size() > 0) begin
        int n;
        n = pendQ.pop_front();
        if (n < 16 || (n >= 20 && n <= 26) || (n >= 28 && n <= 30)) expErr[n] = 1'b1;
      end
      if (testWrEn && lockOpen) pendQ.push_back(int'(testWrIdx));
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    logic expFatal, expIrq;
    expFatal = (expErr[15:0] != 0) || (expErr[26:20] != 0);
    expIrq   = (expErr != 0);
    checks++;
    if (errCode !== expErr) begin
      errors++;
      $display("FAIL %s: errCode actual=%h expected=%h", curReq, errCode, expErr);
    end
    checks++;
    if (fatalAlert !== expFatal || irq !== expIrq) begin
      errors++;
      $display("FAIL R5: fatal/irq actual=%b/%b expected=%b/%b", fatalAlert, irq, expFatal, expIrq);
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic step(input logic [15:0] wr, input logic [15:0] rd, input logic [15:0] st,
                      input logic [6:0] cr, input logic we, input int idx, input logic lk);
    @(negedge clk); #1;
    fifoWrFullErr = wr; fifoRdEmptyErr = rd; fifoStateErr = st;
    coreErr = cr; testWrEn = we; testWrIdx = 5'(idx); lockOpen = lk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, '0, '0, 1'b0, 0, 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk); #1; rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1; rstN = 1'b1;
  endtask

  initial begin
    curReq = "R4"; // reset value zero
    repeat (3) @(negedge clk);
    #1; rstN = 1'b1;
    idle(2);

    curReq = "R1"; // source bits per FIFO
    step(16'h0008, '0, '0, '0, 0, 0, 1);
    step('0, 16'h0200, '0, '0, 0, 0, 1);
    idle(2);
    curReq = "R2"; // type bits 28/29/30
    step('0, '0, 16'h8000, '0, 0, 0, 1);
    idle(2);
    curReq = "R4"; // sticky, then clear by reset
    idle(3);
    doReset(); idle(1);

    curReq = "R3"; // core bits 20..26
    step('0, '0, '0, 7'b0000001, 0, 0, 1);
    step('0, '0, '0, 7'b1000000, 0, 0, 1);
    idle(2);
    doReset(); idle(1);

    curReq = "R8"; // type-only force: irq without fatal (R5)
    step('0, '0, '0, '0, 1, 28, 1);
    idle(3);
    step('0, '0, '0, '0, 1, 12, 1);
    idle(3);
    doReset(); idle(1);

    curReq = "R6"; // forced pulses
    step('0, '0, '0, '0, 1, 5, 1);
    step('0, '0, '0, '0, 1, 22, 1);
    step('0, '0, '0, '0, 1, 30, 1);
    idle(3);
    doReset(); idle(1);

    curReq = "R7"; // lock closed
    step('0, '0, '0, '0, 1, 7, 0);
    step('0, '0, '0, '0, 1, 29, 0);
    idle(3);

    curReq = "R9"; // reserved indices
    step('0, '0, '0, '0, 1, 17, 1);
    step('0, '0, '0, '0, 1, 27, 1);
    step('0, '0, '0, '0, 1, 31, 1);
    step('0, '0, '0, '0, 1, 19, 1);
    idle(3);
    doReset(); idle(1);

    curReq = "R10"; // forced pulse coincides with hardware pulses
    step('0, '0, '0, '0, 1, 3, 1);
    step(16'h0008, '0, '0, 7'b0000100, 0, 0, 1);
    idle(2);
    step('0, '0, '0, '0, 1, 29, 1);
    step(16'h0020, '0, 16'h0001, '0, 0, 0, 1);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule